// File: doc/BRIEF.md
# TDM Time-Slot Assigner

The assigner sits between one serial time-division line and up to seven internal serial channels. A local routing table describes the frame as a chain of slots. Each table entry names a destination channel, a length in units, whether a unit is one bit or eight bits, and whether the entry closes the frame. Each frame sync restarts the walk at the first entry. The walk then steps through the entries until it finishes one marked as closing, or until it runs off the end of the table. After that it idles until the next sync. Receive and transmit have separate tables that are walked in lockstep. A frame can therefore mix byte-wide data slots for some channels with single-bit signalling slots for another.

One clock period is one line bit. On receive, the channel that owns a bit gets a one-cycle strobe and the captured line bit, one cycle after that bit time. On transmit, the owning channel is strobed during the bit time and supplies its bit in the same cycle. The assigner drives that bit onto the line one cycle later, together with an output enable. The enable stays low for slots that belong to no channel, so an external pad can float the line. Software fills the tables through a write port. While the assigner runs, writes are held in a shadow copy and become active at the next frame sync.

Top module: `tsa_assigner`

## Requirements
- R1: After reset, every strobe, `rx_dat`, `txd` and `txd_oe` are low. Every table entry holds 0x0001 (closing, no channel, one bit), so a frame walked after reset strobes no channel.
- R2: A cycle with `fsync` high while `en` is high is the first bit of a frame and is routed by table entry 0. Each later cycle takes the next bit of the walk.
- R3: Entry bit 1 is the unit-size flag: when set, each unit is 8 line bits; when clear, each unit is 1 line bit.
- R4: Entry bits 5:2 hold the unit count minus one, so the value 0 gives one unit and the value 15 gives sixteen units.
- R5: Entry bits 8:6 select the channel. Value k in 1..7 routes the slot to channel k, which drives strobe bit k-1. Value 0 routes the slot to no channel: no strobe is raised and `txd_oe` stays low. At most one strobe per direction is high in any cycle. Bits 15:9 do not affect routing.
- R6: Entry bit 0 marks the closing entry. After its last bit, and also after the last bit of the final table entry, no strobe is raised until the next frame sync.
- R7: A frame sync that arrives before the walk has closed abandons the current walk and starts again at entry 0 in that same cycle.
- R8: For a receive slot of channel k in cycle t, `rx_strb` is one-hot on bit k-1 in cycle t+1 and `rx_dat` carries the `rxd` value of cycle t. `rx_dat` is low whenever no receive strobe is high.
- R9: For a transmit slot of channel k in cycle t, `tx_strb` is one-hot on bit k-1 in cycle t. In cycle t+1, `txd_oe` is high and `txd` equals `tx_bit_in[k-1]` from cycle t. After a cycle with no transmit strobe, `txd_oe` and `txd` are low.
- R10: When `wr_addr` bit 7 is 0 the write goes to the receive table; when it is 1 the write goes to the transmit table. The entry index is `wr_addr` bits 3:0. A write whose bits 6:4 are not all zero changes nothing.
- R11: While `en` is high, a table write changes nothing in the frame in progress. It takes effect from the next frame sync on.
- R12: While `en` is low, no strobe is raised and the walk is stopped. After `en` returns high, routing resumes only with a new frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock; one period per line bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Assigner enable |
| fsync | input | 1 | Frame sync; high in the first bit time of a frame |
| rxd | input | 1 | Serial receive line |
| tx_bit_in | input | 7 | Transmit bit offered by each channel (bit k-1 = channel k) |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table write address (bit 7 selects transmit) |
| wr_data | input | 16 | Table entry to write |
| rx_strb | output | 7 | Per-channel receive bit strobe |
| rx_dat | output | 1 | Receive bit delivered with `rx_strb` |
| tx_strb | output | 7 | Per-channel transmit bit request |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Transmit output enable; low means high impedance |

## Verification
The bench expands its own copy of each table into a per-bit channel schedule and compares every output in every cycle. The cases covered are a mixed byte-and-bit frame, counts above zero, a sync that arrives early, a table with no closing entry, and writes made during a live frame. A design that took the count field literally would shift every later slot by one unit. A design that failed to restart on an early sync would keep strobing the channels of the old walk. A design that applied live writes at once would change the routing in the middle of the frame. Separate receive and transmit tables, together with an out-of-range write aliased onto receive entry 0, catch a wrong address decode. Pausing `en` in the middle of a frame and raising it again without a sync catches a walk that resumes where it stopped.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int CSEL_W  = 3;
  localparam int CNT_W   = 4;
  localparam int AUX_W   = 7;
  localparam int ENTRY_W = AUX_W + CSEL_W + CNT_W + 2;
  localparam int NCH     = (1 << CSEL_W) - 1;
  localparam int LEN_W   = CNT_W + 3;

  typedef struct packed {
    logic [AUX_W-1:0]  aux;
    logic [CSEL_W-1:0] csel;
    logic [CNT_W-1:0]  cnt;
    logic              byt;
    logic              last;
  } tsa_entry_t;

  localparam tsa_entry_t IDLE_ENTRY = tsa_entry_t'(ENTRY_W'(1));
endpackage

// File: rtl/tsa_table.sv
module tsa_table
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               load,
  input  logic [IDX_W-1:0]   rd_idx,
  output tsa_entry_t         rd_entry,
  output tsa_entry_t         first_entry
);
  tsa_entry_t shadow_q [DEPTH];
  tsa_entry_t active_q [DEPTH];

  // shadow takes software writes; active is what the walk reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        shadow_q[i] <= IDLE_ENTRY;
        active_q[i] <= IDLE_ENTRY;
      end
    end else begin
      if (wr_en) shadow_q[wr_idx] <= tsa_entry_t'(wr_data);
      if (load) begin
        for (int i = 0; i < DEPTH; i++) active_q[i] <= shadow_q[i];
      end
    end
  end

  assign rd_entry    = active_q[rd_idx];
  assign first_entry = shadow_q[0];
endmodule

// File: rtl/tsa_walker.sv
module tsa_walker
  import tsa_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fsync,
  input  tsa_entry_t        act_ent,
  input  tsa_entry_t        first_ent,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              slot_valid,
  output logic [CSEL_W-1:0] slot_csel
);
  logic [IDX_W-1:0] idx_q, idx_d, cur_idx;
  logic [LEN_W-1:0] bit_q, bit_d, cur_bit, len_m1;
  logic             run_q, run_d, run;
  logic             end_unit;
  tsa_entry_t       ent;
  logic             unused_aux;

  assign unused_aux = ^{act_ent.aux, first_ent.aux};

  always_comb begin
    // a sync forces the start of a walk in the very cycle it is seen
    cur_idx  = fsync ? '0 : idx_q;
    cur_bit  = fsync ? '0 : bit_q;
    ent      = fsync ? first_ent : act_ent;
    run      = en && (fsync || run_q);
    len_m1   = ent.byt ? {ent.cnt, 3'b111} : {3'b000, ent.cnt};
    end_unit = (cur_bit == len_m1);

    idx_d = idx_q;
    bit_d = bit_q;
    run_d = run_q;
    if (!en) begin
      run_d = 1'b0;
      idx_d = '0;
      bit_d = '0;
    end else if (run) begin
      if (end_unit) begin
        bit_d = '0;
        if (ent.last || (cur_idx == IDX_W'(DEPTH - 1))) begin
          run_d = 1'b0;
          idx_d = '0;
        end else begin
          run_d = 1'b1;
          idx_d = cur_idx + IDX_W'(1);
        end
      end else begin
        run_d = 1'b1;
        idx_d = cur_idx;
        bit_d = cur_bit + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      bit_q <= '0;
      run_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      bit_q <= bit_d;
      run_q <= run_d;
    end
  end

  assign rd_idx     = idx_q;
  assign slot_valid = run;
  assign slot_csel  = ent.csel;
endmodule

// File: rtl/tsa_assigner.sv
module tsa_assigner
  import tsa_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               fsync,
  input  logic               rxd,
  input  logic [NCH-1:0]     tx_bit_in,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [NCH-1:0]     rx_strb,
  output logic               rx_dat,
  output logic [NCH-1:0]     tx_strb,
  output logic               txd,
  output logic               txd_oe
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W-2:0] DEPTH_L = (ADDR_W - 1)'(DEPTH);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // write decode: top address bit picks the direction
  logic             wr_ok;
  logic [1:0]       tbl_wr;
  logic [IDX_W-1:0] wr_idx;
  assign wr_ok     = wr_en && (wr_addr[ADDR_W-2:0] < DEPTH_L);
  assign tbl_wr[0] = wr_ok && !wr_addr[ADDR_W-1];
  assign tbl_wr[1] = wr_ok &&  wr_addr[ADDR_W-1];
  assign wr_idx    = wr_addr[IDX_W-1:0];

  logic              tbl_load;
  logic [1:0]        slot_valid;
  logic [CSEL_W-1:0] slot_csel [2];
  assign tbl_load = !en || fsync;

  // index 0 = receive, 1 = transmit
  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [IDX_W-1:0] rd_idx;
    tsa_entry_t       rd_entry, first_entry;

    tsa_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_en      (tbl_wr[d]),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .load       (tbl_load),
      .rd_idx     (rd_idx),
      .rd_entry   (rd_entry),
      .first_entry(first_entry)
    );

    tsa_walker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_walker (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .en        (en),
      .fsync     (fsync),
      .act_ent   (rd_entry),
      .first_ent (first_entry),
      .rd_idx    (rd_idx),
      .slot_valid(slot_valid[d]),
      .slot_csel (slot_csel[d])
    );
  end

  logic [NCH-1:0] rx_hit, tx_hit;
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign rx_hit[c] = slot_valid[0] && (slot_csel[0] == CSEL_W'(c + 1));
    assign tx_hit[c] = slot_valid[1] && (slot_csel[1] == CSEL_W'(c + 1));
  end

  logic [NCH-1:0] rx_strb_q;
  logic           rx_dat_d, rx_dat_q, txd_d, txd_q, oe_d, oe_q;

  always_comb begin
    rx_dat_d = (|rx_hit) && rxd;
    txd_d    = |(tx_hit & tx_bit_in);
    oe_d     = |tx_hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_strb_q <= '0;
      rx_dat_q  <= 1'b0;
      txd_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      rx_strb_q <= rx_hit;
      rx_dat_q  <= rx_dat_d;
      txd_q     <= txd_d;
      oe_q      <= oe_d;
    end
  end

  assign rx_strb = rx_strb_q;
  assign rx_dat  = rx_dat_q;
  assign tx_strb = tx_hit;
  assign txd     = txd_q;
  assign txd_oe  = oe_q;
endmodule

// File: rtl/tsa_assigner_chk.sv
module tsa_assigner_chk #(
  parameter int NCH = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic [NCH-1:0] rx_strb,
  input logic           rx_dat,
  input logic [NCH-1:0] tx_strb,
  input logic           txd,
  input logic           txd_oe
);
  // R5
  rx_strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_strb));

  // R5
  tx_strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_strb));

  // R9
  tx_oe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_strb) |=> txd_oe);

  // R9
  tx_oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|tx_strb) |=> !txd_oe);

  // R9
  txd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> !txd);

  // R8
  rx_dat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strb == '0) |-> !rx_dat);

  // R12
  off_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (tx_strb == '0));

  // R12
  off_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_strb == '0));
endmodule

bind tsa_assigner tsa_assigner_chk #(.NCH(tsa_pkg::NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en),
  .rx_strb(rx_strb),
  .rx_dat (rx_dat),
  .tx_strb(tx_strb),
  .txd    (txd),
  .txd_oe (txd_oe)
);

// File: tb/tsa_assigner_bench.sv
module tsa_assigner_bench;
  logic        clk, rst_n, en, fsync, rxd, wr_en;
  logic [6:0]  tx_bit_in, rx_strb, tx_strb;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        rx_dat, txd, txd_oe;

  tsa_assigner u_tsa_assigner (
    .clk(clk), .rst_n(rst_n), .en(en), .fsync(fsync), .rxd(rxd),
    .tx_bit_in(tx_bit_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_strb(rx_strb), .rx_dat(rx_dat), .tx_strb(tx_strb), .txd(txd), .txd_oe(txd_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk, n_fail, pos;
  logic [15:0] sh [2][16];
  int sched [2][2048];
  int slen [2];
  logic en_b, wr_pend;
  logic [7:0] wr_a;
  logic [15:0] wr_d;
  logic [6:0] e_rxs;
  logic e_rxd, e_txd, e_oe;
  string prev_tag;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ent(int c, int n, int b, int l);
    return {7'b0, 3'(c), 4'(n), 1'(b), 1'(l)};
  endfunction

  function automatic logic [6:0] oh(int c);
    return (c == 0) ? 7'b0 : 7'(1 << (c - 1));
  endfunction

  task automatic rebuild();
    logic [15:0] e;
    int bits;
    for (int d = 0; d < 2; d++) begin
      slen[d] = 0;
      for (int i = 0; i < 16; i++) begin
        e = sh[d][i];
        bits = (int'(e[5:2]) + 1) * (e[1] ? 8 : 1);
        for (int b = 0; b < bits; b++) begin
          sched[d][slen[d]] = int'(e[8:6]);
          slen[d]++;
        end
        if (e[0]) break;
      end
    end
  endtask

  task automatic tick(input logic fs, input string tag);
    logic rv;
    logic [6:0] tv;
    int chr, cht;
    @(negedge clk);
    chk(prev_tag, "rx_strb", 32'(rx_strb), 32'(e_rxs));
    chk(prev_tag, "rx_dat", 32'(rx_dat), 32'(e_rxd));
    chk(prev_tag, "txd", 32'(txd), 32'(e_txd));
    chk(prev_tag, "txd_oe", 32'(txd_oe), 32'(e_oe));
    rv = 1'($urandom);
    tv = 7'($urandom);
    en = en_b; fsync = fs; rxd = rv; tx_bit_in = tv;
    wr_en = wr_pend; wr_addr = wr_a; wr_data = wr_d;
    if (!en_b) pos = -1;
    else if (fs) begin rebuild(); pos = 0; end
    else if (pos >= 0) pos++;
    chr = (en_b && pos >= 0 && pos < slen[0]) ? sched[0][pos] : 0;
    cht = (en_b && pos >= 0 && pos < slen[1]) ? sched[1][pos] : 0;
    #1;
    chk(tag, "tx_strb", 32'(tx_strb), 32'(oh(cht)));
    e_rxs = oh(chr);
    e_rxd = (chr != 0) ? rv : 1'b0;
    e_oe  = (cht != 0);
    e_txd = (cht != 0) ? tv[cht-1] : 1'b0;
    if (wr_pend) begin
      if (wr_a[6:0] < 7'd16) sh[wr_a[7]][wr_a[3:0]] = wr_d;
      wr_pend = 1'b0;
    end
    prev_tag = tag;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, string tag);
    wr_pend = 1'b1; wr_a = a; wr_d = d;
    tick(1'b0, tag);
  endtask

  task automatic frame(int n, string tag);
    tick(1'b1, tag);
    for (int i = 1; i < n; i++) tick(1'b0, tag);
  endtask

  task automatic t_reset();
    chk("R1", "rx_strb", 32'(rx_strb), 0);
    chk("R1", "tx_strb", 32'(tx_strb), 0);
    chk("R1", "txd_oe", 32'(txd_oe), 0);
    chk("R1", "txd", 32'(txd), 0);
    chk("R1", "rx_dat", 32'(rx_dat), 0);
  endtask

  task automatic t_idle_table();
    en_b = 1'b1;
    frame(10, "R1");
  endtask

  task automatic t_mixed();
    en_b = 1'b0;
    for (int d = 0; d < 2; d++) begin
      wr(8'(d * 128 + 0), ent(1, 0, 1, 0), "R10");
      wr(8'(d * 128 + 1), ent(2, 0, 0, 0), "R10");
      wr(8'(d * 128 + 2), ent(0, 0, 0, 0), "R5");
      wr(8'(d * 128 + 3), ent(3, 0, 1, 0), "R3");
      wr(8'(d * 128 + 4), ent(2, 0, 0, 1), "R6");
    end
    en_b = 1'b1;
    frame(26, "R3");
    frame(20, "R2");
    tick(1'b0, "R6");
  endtask

  task automatic t_abort();
    frame(10, "R7");
    frame(24, "R7");
  endtask

  task automatic t_disable();
    frame(5, "R12");
    en_b = 1'b0;
    for (int i = 0; i < 4; i++) tick(1'b0, "R12");
    en_b = 1'b1;
    for (int i = 0; i < 6; i++) tick(1'b0, "R12");
    frame(22, "R12");
  endtask

  task automatic t_counts();
    en_b = 1'b0;
    for (int d = 0; d < 2; d++) begin
      wr(8'(d * 128 + 0), ent(4, 2, 0, 0), "R4");
      wr(8'(d * 128 + 1), ent(5, 1, 1, 0), "R4");
      wr(8'(d * 128 + 2), ent(0, 1, 1, 0), "R4");
      wr(8'(d * 128 + 3), ent(6, 0, 0, 1), "R4");
    end
    en_b = 1'b1;
    frame(40, "R4");
  endtask

  task automatic t_tbl_end();
    for (int i = 0; i < 16; i++) begin
      wr(8'(i), ent(1, 0, 0, 0), "R6");
      wr(8'(128 + i), ent(6, 0, 0, 0), "R6");
    end
    frame(24, "R6");
  endtask

  task automatic t_split();
    en_b = 1'b0;
    wr(8'h00, ent(1, 0, 1, 1), "R10");
    wr(8'h80, ent(7, 3, 0, 0), "R10");
    wr(8'h81, ent(2, 0, 0, 1), "R10");
    wr(8'h40, ent(3, 0, 1, 1), "R10");
    en_b = 1'b1;
    frame(12, "R10");
  endtask

  task automatic t_live_write();
    tick(1'b1, "R11");
    tick(1'b0, "R11");
    wr(8'h00, ent(5, 1, 0, 1), "R11");
    wr(8'h80, ent(4, 0, 1, 1), "R11");
    for (int i = 0; i < 8; i++) tick(1'b0, "R11");
    frame(12, "R11");
  endtask

  initial begin
    n_chk = 0; n_fail = 0; pos = -1;
    rst_n = 1'b0; en = 1'b0; fsync = 1'b0; rxd = 1'b0; tx_bit_in = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    en_b = 1'b0; wr_pend = 1'b0; wr_a = '0; wr_d = '0;
    e_rxs = '0; e_rxd = 1'b0; e_txd = 1'b0; e_oe = 1'b0;
    prev_tag = "R1";
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 16; i++) sh[d][i] = 16'h0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_table();
    t_mixed();
    t_abort();
    t_disable();
    t_counts();
    t_tbl_end();
    t_split();
    t_live_write();
    tick(1'b0, "R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule